// File: doc/BRIEF.md
# System control register bank

This block is a byte-wide bank of I/O ports that a small embedded platform uses for board identification and system control. A synchronous bus supplies an address, a write byte and separate read and write strobes. One standalone port combines a processor reset request with a byte-order flag. A contiguous window of ports returns fixed identification and feature bytes, holds a few control bits, and turns certain writes into side-band actions: an indicator lamp, two lock-toggle pulse channels and an I/O-map mode line.

Every output is registered. A write takes effect on the clock edge where the write strobe is sampled. Read data is captured on the edge where the read strobe is sampled and holds until the next read. When the read and write strobes are high together, the read sees the state from before the write. A write to an undefined port inside the window raises a one-cycle error pulse. Addresses outside both decoded ranges are not claimed by the block.

Top module: `sysctl_bank`

## Requirements
- R1: While reset is asserted and after it is released, the following all read 0: `cpu_reset`, `little_endian`, `light_on`, `map_mode`, the control nibble, `lock_pulse`, `wr_err` and `io_rdata`.
- R2: A write to port 0x092 sets `cpu_reset` from data bit 0 and `little_endian` from data bit 1, from the cycle after the write.
- R3: A read of port 0x092 returns `little_endian` in bit 1, with every other bit 0.
- R4: Reads return these fixed bytes: 0x800 gives 0xEF, 0x802 gives 0xAD, 0x803 gives 0xE0, 0x80C gives 0x3C, 0x810 gives 0x39, 0x818 gives 0x00 and 0x823 gives 0x03. Writes to 0x800, 0x802 and 0x803 change nothing and raise no error.
- R5: A write to 0x808 sets `light_on` from data bit 0.
- R6: Regardless of the data, a write to 0x810 makes `lock_pulse[0]` high for exactly the next cycle, and a write to 0x812 does the same for `lock_pulse[1]`. Back-to-back writes give back-to-back pulses.
- R7: A write to 0x81C stores data bits 3:0 as the control nibble. A read of 0x81C returns the nibble in bits 3:0, with bits 7:4 equal to 0.
- R8: A write to 0x850 latches data bit 0 onto `map_mode`. A read of 0x850 returns that bit in bit 0, with every other bit 0.
- R9: A read returns 0xFF for each of the following: 0x814, 0x808, 0x812, a hole in the window 0x800..0x851, and any address outside both decoded ranges. A write to 0x814 changes no output.
- R10: `io_rdata` changes only on the edge after a cycle with `io_rd` high and holds otherwise. When the read and write strobes are high together, the read returns the value from before the write.
- R11: `wr_err` pulses for one cycle after a write to a hole in the window or to 0x80C, 0x818 or 0x823. A write outside both decoded ranges raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Byte port address |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_rdata | output | 8 | Registered read data |
| cpu_reset | output | 1 | Processor reset request level |
| little_endian | output | 1 | Byte-order flag |
| map_mode | output | 1 | I/O-map mode line |
| light_on | output | 1 | Indicator lamp level |
| lock_pulse | output | 2 | One-cycle lock-toggle pulses, channel 1 in bit 0 |
| wr_err | output | 1 | One-cycle pulse on a write to an undefined port |

## Verification
A read and a write can land in the same cycle. When both strobes are high on the same port, the read result competes with the state update. The bench provokes this on the control-nibble port and on the reset/byte-order port. It expects the read to return the value from before the write and a following read to show the new value. A second overlap is a lock-toggle pulse or error pulse coinciding with held read data. The per-clock reference model judges every output in every cycle, so a pulse that is stretched or missing and read data that changes when it should hold are both caught.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef enum logic [3:0] {
        K_NONE,
        K_RSTEND,
        K_IDENT,
        K_IDENT_X,
        K_LIGHT,
        K_LOCK1,
        K_LOCK2,
        K_INVAL,
        K_SYSCTL,
        K_MAPMODE,
        K_HOLE
    } port_kind_e;

    localparam int NUM_LOCK = 2;

    localparam int OFF_CPUCFG    = 'h00;
    localparam int OFF_FEAT      = 'h02;
    localparam int OFF_STAT      = 'h03;
    localparam int OFF_LIGHT     = 'h08;
    localparam int OFF_EQUIP     = 'h0C;
    localparam int OFF_LOCK1     = 'h10;
    localparam int OFF_LOCK2     = 'h12;
    localparam int OFF_INVAL     = 'h14;
    localparam int OFF_KEYLOCK   = 'h18;
    localparam int OFF_SYSCTL    = 'h1C;
    localparam int OFF_CACHEINFO = 'h23;
    localparam int OFF_MAPMODE   = 'h50;

    function automatic logic [7:0] ident_byte(input logic [7:0] off);
        case (off)
            8'h00:   return 8'hEF;
            8'h02:   return 8'hAD;
            8'h03:   return 8'hE0;
            8'h0C:   return 8'h3C;
            8'h10:   return 8'h39;
            8'h18:   return 8'h00;
            8'h23:   return 8'h03;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic port_kind_e lock_kind(input int ch);
        return (ch == 0) ? K_LOCK1 : K_LOCK2;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 'h800,
    parameter int                WIN_SPAN    = 'h52,
    parameter logic [ADDR_W-1:0] RSTEND_PORT = 'h92
) (
    input  logic [ADDR_W-1:0] addr,
    output port_kind_e        kind,
    output logic [7:0]        off
);
    localparam logic [ADDR_W-1:0] WIN_END = WIN_BASE + ADDR_W'(WIN_SPAN);

    logic [ADDR_W-1:0] rel;
    logic              in_win;

    assign rel    = addr - WIN_BASE;
    assign off    = rel[7:0];
    assign in_win = (addr >= WIN_BASE) && (addr < WIN_END);

    always_comb begin
        kind = K_NONE;
        if (addr == RSTEND_PORT) begin
            kind = K_RSTEND;
        end else if (in_win) begin
            unique case (rel)
                ADDR_W'(OFF_CPUCFG),
                ADDR_W'(OFF_FEAT),
                ADDR_W'(OFF_STAT):      kind = K_IDENT;
                ADDR_W'(OFF_EQUIP),
                ADDR_W'(OFF_KEYLOCK),
                ADDR_W'(OFF_CACHEINFO): kind = K_IDENT_X;
                ADDR_W'(OFF_LIGHT):     kind = K_LIGHT;
                ADDR_W'(OFF_LOCK1):     kind = K_LOCK1;
                ADDR_W'(OFF_LOCK2):     kind = K_LOCK2;
                ADDR_W'(OFF_INVAL):     kind = K_INVAL;
                ADDR_W'(OFF_SYSCTL):    kind = K_SYSCTL;
                ADDR_W'(OFF_MAPMODE):   kind = K_MAPMODE;
                default:                kind = K_HOLE;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
    import sysctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  port_kind_e          kind,
    input  logic [3:0]          wdata,
    output logic                cpu_reset,
    output logic                little_endian,
    output logic                light_on,
    output logic                map_mode,
    output logic [3:0]          sys_nib,
    output logic [NUM_LOCK-1:0] lock_pulse,
    output logic                wr_err
);
    logic [NUM_LOCK-1:0] hit;

    for (genvar c = 0; c < NUM_LOCK; c++) begin : g_lock
        assign hit[c] = wr_en && (kind == lock_kind(c));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_reset     <= 1'b0;
            little_endian <= 1'b0;
            light_on      <= 1'b0;
            map_mode      <= 1'b0;
            sys_nib       <= 4'h0;
            lock_pulse    <= '0;
            wr_err        <= 1'b0;
        end else begin
            lock_pulse <= hit;
            wr_err     <= 1'b0;
            if (wr_en) begin
                unique case (kind)
                    K_RSTEND: begin
                        cpu_reset     <= wdata[0];
                        little_endian <= wdata[1];
                    end
                    K_LIGHT:           light_on <= wdata[0];
                    K_SYSCTL:          sys_nib  <= wdata;
                    K_MAPMODE:         map_mode <= wdata[0];
                    K_HOLE, K_IDENT_X: wr_err   <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // R2
    rstend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == K_RSTEND) |=>
            (cpu_reset == $past(wdata[0]) && little_endian == $past(wdata[1])));

    // R6
    lock_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lock_pulse));

    // R6
    lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_pulse != '0) |-> $past(wr_en));

    // R11
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en));

    // R7
    nib_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && kind == K_SYSCTL) |=> $stable(sys_nib));

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
    import sysctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  port_kind_e kind,
    input  logic [7:0] off,
    input  logic       little_endian,
    input  logic       map_mode,
    input  logic [3:0] sys_nib,
    output logic [7:0] rd_data
);
    logic [7:0] rd_next;

    always_comb begin
        unique case (kind)
            K_RSTEND:                   rd_next = {6'b0, little_endian, 1'b0};
            K_IDENT, K_IDENT_X, K_LOCK1: rd_next = ident_byte(off);
            K_SYSCTL:                   rd_next = {4'b0, sys_nib};
            K_MAPMODE:                  rd_next = {7'b0, map_mode};
            default:                    rd_next = 8'hFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= 8'h00;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end
    end

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R7
    rd_nib_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == K_SYSCTL) |=> (rd_data[7:4] == 4'h0));

    // R3
    rd_rstend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == K_RSTEND) |=> (rd_data[7:2] == 6'h0 && rd_data[0] == 1'b0));

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 'h800,
    parameter int                WIN_SPAN    = 'h52,
    parameter logic [ADDR_W-1:0] RSTEND_PORT = 'h92
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic [7:0]          io_wdata,
    input  logic                io_rd,
    input  logic                io_wr,
    output logic [7:0]          io_rdata,
    output logic                cpu_reset,
    output logic                little_endian,
    output logic                map_mode,
    output logic                light_on,
    output logic [NUM_LOCK-1:0] lock_pulse,
    output logic                wr_err
);
    port_kind_e kind;
    logic [7:0] off;
    logic [3:0] sys_nib;

    sysctl_decode #(
        .ADDR_W      (ADDR_W),
        .WIN_BASE    (WIN_BASE),
        .WIN_SPAN    (WIN_SPAN),
        .RSTEND_PORT (RSTEND_PORT)
    ) u_decode (
        .addr (io_addr),
        .kind (kind),
        .off  (off)
    );

    sysctl_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (io_wr),
        .kind          (kind),
        .wdata         (io_wdata[3:0]),
        .cpu_reset     (cpu_reset),
        .little_endian (little_endian),
        .light_on      (light_on),
        .map_mode      (map_mode),
        .sys_nib       (sys_nib),
        .lock_pulse    (lock_pulse),
        .wr_err        (wr_err)
    );

    sysctl_rdmux u_rdmux (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_en         (io_rd),
        .kind          (kind),
        .off           (off),
        .little_endian (little_endian),
        .map_mode      (map_mode),
        .sys_nib       (sys_nib),
        .rd_data       (io_rdata)
    );

    // R9
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && (kind == K_INVAL || kind == K_IDENT || kind == K_NONE)) |=>
            (!wr_err && lock_pulse == '0 && $stable(map_mode) && $stable(light_on)
             && $stable(cpu_reset) && $stable(little_endian)));

endmodule

// File: tb/test_sysctl_bank.sv
`timescale 1ns/1ps
module test_sysctl_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [7:0]  io_wdata = 8'h0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_rdata;
    logic        cpu_reset, little_endian, map_mode, light_on, wr_err;
    logic [1:0]  lock_pulse;

    always #4 clk = ~clk;

    sysctl_bank i_sysctl_bank (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
        .cpu_reset(cpu_reset), .little_endian(little_endian), .map_mode(map_mode),
        .light_on(light_on), .lock_pulse(lock_pulse), .wr_err(wr_err)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [7:0] m_rd;
    logic       m_rst, m_le, m_light, m_mode, m_err;
    logic [3:0] m_nib;
    logic [1:0] m_lock;

    function automatic logic [7:0] ref_read(input logic [15:0] a);
        case (a)
            16'h092: return {6'b0, m_le, 1'b0};
            16'h800: return 8'hEF;
            16'h802: return 8'hAD;
            16'h803: return 8'hE0;
            16'h80C: return 8'h3C;
            16'h810: return 8'h39;
            16'h818: return 8'h00;
            16'h823: return 8'h03;
            16'h81C: return {4'b0, m_nib};
            16'h850: return {7'b0, m_mode};
            default: return 8'hFF;
        endcase
    endfunction

    task automatic compare(input string rq);
        bit bad = 1'b0;
        vectors++;
        if (io_rdata !== m_rd) begin
            $display("FAIL %s io_rdata actual %02h expected %02h", rq, io_rdata, m_rd); bad = 1;
        end
        if (cpu_reset !== m_rst) begin
            $display("FAIL R2 cpu_reset actual %0b expected %0b", cpu_reset, m_rst); bad = 1;
        end
        if (little_endian !== m_le) begin
            $display("FAIL R2 little_endian actual %0b expected %0b", little_endian, m_le); bad = 1;
        end
        if (light_on !== m_light) begin
            $display("FAIL R5 light_on actual %0b expected %0b", light_on, m_light); bad = 1;
        end
        if (map_mode !== m_mode) begin
            $display("FAIL R8 map_mode actual %0b expected %0b", map_mode, m_mode); bad = 1;
        end
        if (lock_pulse !== m_lock) begin
            $display("FAIL R6 lock_pulse actual %02b expected %02b", lock_pulse, m_lock); bad = 1;
        end
        if (wr_err !== m_err) begin
            $display("FAIL R11 wr_err actual %0b expected %0b", wr_err, m_err); bad = 1;
        end
        if (bad) miscompares++;
    endtask

    task automatic step(input logic [15:0] a, input logic [7:0] d,
                        input logic r, input logic w, input string rq);
        io_addr = a; io_wdata = d; io_rd = r; io_wr = w;
        @(posedge clk);
        if (r) m_rd = ref_read(a);
        m_lock = 2'b00;
        m_err  = 1'b0;
        if (w) begin
            case (a)
                16'h092: begin m_rst = d[0]; m_le = d[1]; end
                16'h808: m_light = d[0];
                16'h810: m_lock = 2'b01;
                16'h812: m_lock = 2'b10;
                16'h81C: m_nib = d[3:0];
                16'h850: m_mode = d[0];
                16'h800, 16'h802, 16'h803, 16'h814: ;
                default: if (a >= 16'h800 && a < 16'h852) m_err = 1'b1;
            endcase
        end
        @(negedge clk);
        compare(rq);
    endtask

    task automatic rd(input logic [15:0] a, input string rq);
        step(a, 8'h00, 1'b1, 1'b0, rq);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string rq);
        step(a, d, 1'b0, 1'b1, rq);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            $display("FAIL watchdog expired actual running expected finished");
            miscompares++;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        m_rd = 8'h00; m_rst = 0; m_le = 0; m_light = 0; m_mode = 0;
        m_err = 0; m_nib = 4'h0; m_lock = 2'b00;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");
        rd(16'h81C, "R1");
        rd(16'h850, "R1");
        rd(16'h092, "R3");
        // R4 identification bytes
        rd(16'h800, "R4"); rd(16'h802, "R4"); rd(16'h803, "R4"); rd(16'h80C, "R4");
        rd(16'h810, "R4"); rd(16'h818, "R4"); rd(16'h823, "R4");
        // R2 / R3 reset and byte-order port
        wr(16'h092, 8'h03, "R2"); rd(16'h092, "R3");
        wr(16'h092, 8'hFE, "R2"); rd(16'h092, "R3");
        wr(16'h092, 8'h01, "R2"); rd(16'h092, "R3");
        wr(16'h092, 8'h00, "R2");
        // R5 lamp
        wr(16'h808, 8'h01, "R5"); wr(16'h808, 8'hFE, "R5"); wr(16'h808, 8'hFF, "R5");
        // R6 lock pulses
        wr(16'h810, 8'h00, "R6"); step(16'h000, 8'h00, 0, 0, "R6");
        wr(16'h812, 8'hA5, "R6"); step(16'h000, 8'h00, 0, 0, "R6");
        wr(16'h810, 8'hFF, "R6"); wr(16'h810, 8'h12, "R6"); wr(16'h812, 8'h00, "R6");
        rd(16'h810, "R6");
        // R7 control nibble
        wr(16'h81C, 8'hB7, "R7"); rd(16'h81C, "R7");
        wr(16'h81C, 8'h5A, "R7"); rd(16'h81C, "R7");
        // R8 map mode
        wr(16'h850, 8'hFF, "R8"); rd(16'h850, "R8");
        wr(16'h850, 8'hFE, "R8"); rd(16'h850, "R8");
        // R4 writes to read-only identity ports are ignored
        wr(16'h800, 8'h00, "R4"); wr(16'h802, 8'h11, "R4"); wr(16'h803, 8'h22, "R4");
        rd(16'h800, "R4"); rd(16'h802, "R4"); rd(16'h803, "R4");
        // R9 invalidate port and unmapped reads
        wr(16'h814, 8'hFF, "R9"); rd(16'h814, "R9");
        rd(16'h801, "R9"); rd(16'h851, "R9"); rd(16'h852, "R9"); rd(16'h7FF, "R9");
        rd(16'h091, "R9"); rd(16'h093, "R9"); rd(16'h808, "R9"); rd(16'h812, "R9");
        // R11 write errors
        wr(16'h801, 8'h55, "R11"); wr(16'h80C, 8'h00, "R11"); wr(16'h818, 8'h00, "R11");
        wr(16'h823, 8'h00, "R11"); wr(16'h851, 8'h00, "R11");
        wr(16'h852, 8'h00, "R11"); wr(16'h093, 8'h00, "R11"); wr(16'h7FF, 8'h00, "R11");
        // R10 hold and same-cycle read and write
        wr(16'h81C, 8'h03, "R10"); rd(16'h81C, "R10");
        step(16'h800, 8'h00, 0, 0, "R10"); step(16'h810, 8'h00, 0, 1, "R10");
        step(16'h81C, 8'h0C, 1, 1, "R10"); rd(16'h81C, "R10");
        step(16'h092, 8'h02, 1, 1, "R10"); rd(16'h092, "R10");
        step(16'h801, 8'h00, 1, 1, "R10");
        step(16'h000, 8'h00, 0, 0, "R10");
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule